// File: doc/BRIEF.md
# Request Packetizer Network Interface

This block sits between an initiator core and an on-chip packet network. On the core side it speaks a simple synchronous master/slave protocol. The core drives a 3-bit command with an address and write data, and the block answers with a command accept. Later it returns a response code with read data. On the network side it sends fixed-width flits out and takes flits in, each direction with a valid/ready handshake.

An accepted request loads a header register and a payload register. The header is built from the route, the command and the address. The route comes from a small lookup table indexed by the top address bits. The header is sent first, lowest chunk first. A write then sends its payload. The last flit of every packet carries a tail marker.

Returning flits are collected until a tail flit arrives. The rebuilt response is then presented to the core and held until the core takes it. The request path and the response path are independent, so the core can issue new requests while responses are still outstanding.

Top module: `niPacketizer`

## Requirements
- R1: After reset, reqAccept is 1, flitOutValid is 0, rspValid is 0 and flitInReady is 1.
- R2: Command code 1 is a write and code 2 is a read. Codes 0 and 3 to 7 start no packet and leave reqAccept at 1.
- R3: reqAccept is 1 exactly when no request packet is in flight. It goes to 0 in the cycle after a write or read is accepted and returns to 1 in the cycle after the tail flit is taken.
- R4: The route is 8 bits and is looked up by reqAddr[31:30]. The table maps region 0 to 0x03, region 1 to 0x05, region 2 to 0x09 and region 3 to 0x0C.
- R5: With 16-bit flits, a packet starts with three header flits: reqAddr[15:0], then reqAddr[31:16], then a flit holding the command in bits 2:0 and the route in bits 10:3.
- R6: A write packet adds two payload flits after the header: reqData[15:0], then reqData[31:16]. A read packet has no payload flits.
- R7: flitOutTail is 1 on the last flit of a packet and 0 on every other flit. Flit bits above the header fields (15:11 of the third header flit) are 0.
- R8: While flitOutValid is 1 and flitOutReady is 0, flitOutData and flitOutTail hold their values.
- R9: In a response packet, bits 2:0 of the first flit are the response code. Any later flits carry read data, low half first. rspValid rises in the cycle after the tail flit is taken. A single-flit response gives rspData 0.
- R10: A presented response keeps rspCode and rspData stable until rspAccept is 1. While it is held, flitInReady is 0.
- R11: New requests are accepted while responses to earlier requests are outstanding or are being held at the core side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqCmd | input | 3 | Core command: 0 idle, 1 write, 2 read |
| reqAddr | input | ADDR_W | Request address |
| reqData | input | DATA_W | Write data |
| reqAccept | output | 1 | Command accept |
| rspCode | output | 3 | Response code to the core |
| rspData | output | DATA_W | Read data to the core |
| rspValid | output | 1 | Response present |
| rspAccept | input | 1 | Core takes the response |
| flitOutData | output | FLIT_W | Outgoing flit |
| flitOutTail | output | 1 | Outgoing flit is last of packet |
| flitOutValid | output | 1 | Outgoing flit valid |
| flitOutReady | input | 1 | Network takes outgoing flit |
| flitInData | input | FLIT_W | Incoming flit |
| flitInTail | input | 1 | Incoming flit is last of packet |
| flitInValid | input | 1 | Incoming flit valid |
| flitInReady | output | 1 | Block takes incoming flit |

## Verification
A wrong flit index or a stale header register shows up as a wrong flit or a misplaced tail. This appears on the very next flit handshake, because each outgoing flit is compared in order against flits built from the request. A stuck busy state shows up as reqAccept staying low after the tail flit. A lost hold state shows up as the response changing, or flitInReady rising, before the core takes it, within one cycle. Response reassembly errors appear as a wrong code or wrong data on the first response taken after the bad flit.

// File: rtl/niPkg.sv
package niPkg;
  localparam int SEL_W = 4;

  localparam logic [2:0] CMD_IDLE  = 3'd0;
  localparam logic [2:0] CMD_WRITE = 3'd1;
  localparam logic [2:0] CMD_READ  = 3'd2;

  typedef struct packed {
    logic             loadReq;
    logic [SEL_W-1:0] txSel;
    logic             rxCapture;
    logic [SEL_W-1:0] rxSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/niCtrl.sv
module niCtrl
  import niPkg::*;
#(
  parameter int HDR_FLITS = 3,
  parameter int PAY_FLITS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  reqCmd,
  output logic        reqAccept,
  output logic        flitOutValid,
  output logic        flitOutTail,
  input  logic        flitOutReady,
  input  logic        flitInValid,
  input  logic        flitInTail,
  output logic        flitInReady,
  output logic        rspValid,
  input  logic        rspAccept,
  output ctrlStrobe_t strobe
);
  localparam logic [SEL_W-1:0] LAST_WR = SEL_W'(HDR_FLITS + PAY_FLITS - 1);
  localparam logic [SEL_W-1:0] LAST_RD = SEL_W'(HDR_FLITS - 1);

  logic             busy;
  logic             txWrite;
  logic [SEL_W-1:0] txIdx;
  logic [SEL_W-1:0] rxIdx;
  logic             rspHold;
  logic             isReq;
  logic             txFire;
  logic             rxFire;
  logic             txLast;

  assign isReq        = (reqCmd == CMD_WRITE) || (reqCmd == CMD_READ);
  assign reqAccept    = !busy;
  assign txLast       = txIdx == (txWrite ? LAST_WR : LAST_RD);
  assign flitOutValid = busy;
  assign flitOutTail  = busy && txLast;
  assign txFire       = busy && flitOutReady;
  assign flitInReady  = !rspHold;
  assign rxFire       = flitInValid && !rspHold;
  assign rspValid     = rspHold;

  always_comb begin
    strobe.loadReq   = !busy && isReq;
    strobe.txSel     = txIdx;
    strobe.rxCapture = rxFire;
    strobe.rxSel     = rxIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      txWrite <= 1'b0;
      txIdx   <= '0;
    end else if (strobe.loadReq) begin
      busy    <= 1'b1;
      txWrite <= (reqCmd == CMD_WRITE);
      txIdx   <= '0;
    end else if (txFire) begin
      if (txLast) busy <= 1'b0;
      else        txIdx <= txIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxIdx   <= '0;
      rspHold <= 1'b0;
    end else begin
      if (rxFire) begin
        if (flitInTail) begin
          rxIdx   <= '0;
          rspHold <= 1'b1;
        end else if (rxIdx != '1) begin
          rxIdx <= rxIdx + 1'b1;
        end
      end else if (rspHold && rspAccept) begin
        rspHold <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/niDatapath.sv
module niDatapath
  import niPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int FLIT_W    = 16,
  parameter int ROUTE_W   = 8,
  parameter int REGION_W  = 2,
  parameter logic [(1<<REGION_W)*ROUTE_W-1:0] ROUTE_TABLE = 32'h0C_09_05_03,
  parameter int HDR_FLITS = 3,
  parameter int PAY_FLITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [2:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic [FLIT_W-1:0] flitOutData,
  input  logic [FLIT_W-1:0] flitInData,
  output logic [2:0]        rspCode,
  output logic [DATA_W-1:0] rspData
);
  localparam int NREG  = 1 << REGION_W;
  localparam int HDR_W = ROUTE_W + 3 + ADDR_W;
  localparam int TOT   = HDR_FLITS + PAY_FLITS;

  logic [ROUTE_W-1:0] routeTab [NREG];
  for (genvar g = 0; g < NREG; g++) begin : gRoute
    assign routeTab[g] = ROUTE_TABLE[g*ROUTE_W +: ROUTE_W];
  end

  logic [REGION_W-1:0]         region;
  logic [HDR_W-1:0]            hdrReg;
  logic [DATA_W-1:0]           payReg;
  logic [HDR_FLITS*FLIT_W-1:0] hdrPad;
  logic [PAY_FLITS*FLIT_W-1:0] payPad;
  logic [TOT*FLIT_W-1:0]       txVec;
  logic [PAY_FLITS*FLIT_W-1:0] rxBuf;
  logic [2:0]                  codeReg;

  assign region = reqAddr[ADDR_W-1 -: REGION_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrReg <= '0;
      payReg <= '0;
    end else if (strobe.loadReq) begin
      hdrReg <= {routeTab[region], reqCmd, reqAddr};
      payReg <= reqData;
    end
  end

  always_comb begin
    hdrPad = '0;
    hdrPad[HDR_W-1:0] = hdrReg;
    payPad = '0;
    payPad[DATA_W-1:0] = payReg;
  end

  assign txVec       = {payPad, hdrPad};
  assign flitOutData = txVec[strobe.txSel*FLIT_W +: FLIT_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeReg <= '0;
      rxBuf   <= '0;
    end else if (strobe.rxCapture) begin
      if (strobe.rxSel == '0) begin
        codeReg <= flitInData[2:0];
        rxBuf   <= '0;
      end else begin
        for (int k = 0; k < PAY_FLITS; k++) begin
          if (strobe.rxSel == SEL_W'(k + 1)) rxBuf[k*FLIT_W +: FLIT_W] <= flitInData;
        end
      end
    end
  end

  assign rspCode = codeReg;
  assign rspData = rxBuf[DATA_W-1:0];
endmodule

// File: rtl/niPacketizer.sv
module niPacketizer
  import niPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int FLIT_W   = 16,
  parameter int ROUTE_W  = 8,
  parameter int REGION_W = 2,
  parameter logic [(1<<REGION_W)*ROUTE_W-1:0] ROUTE_TABLE = 32'h0C_09_05_03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqAccept,
  output logic [2:0]        rspCode,
  output logic [DATA_W-1:0] rspData,
  output logic              rspValid,
  input  logic              rspAccept,
  output logic [FLIT_W-1:0] flitOutData,
  output logic              flitOutTail,
  output logic              flitOutValid,
  input  logic              flitOutReady,
  input  logic [FLIT_W-1:0] flitInData,
  input  logic              flitInTail,
  input  logic              flitInValid,
  output logic              flitInReady
);
  localparam int HDR_W     = ROUTE_W + 3 + ADDR_W;
  localparam int HDR_FLITS = (HDR_W + FLIT_W - 1) / FLIT_W;
  localparam int PAY_FLITS = (DATA_W + FLIT_W - 1) / FLIT_W;

  ctrlStrobe_t strobe;

  niCtrl #(.HDR_FLITS(HDR_FLITS), .PAY_FLITS(PAY_FLITS)) uCtrl (
    .clk(clk), .rstN(rstN), .reqCmd(reqCmd), .reqAccept(reqAccept),
    .flitOutValid(flitOutValid), .flitOutTail(flitOutTail), .flitOutReady(flitOutReady),
    .flitInValid(flitInValid), .flitInTail(flitInTail), .flitInReady(flitInReady),
    .rspValid(rspValid), .rspAccept(rspAccept), .strobe(strobe)
  );

  niDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLIT_W(FLIT_W), .ROUTE_W(ROUTE_W),
    .REGION_W(REGION_W), .ROUTE_TABLE(ROUTE_TABLE),
    .HDR_FLITS(HDR_FLITS), .PAY_FLITS(PAY_FLITS)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqCmd(reqCmd), .reqAddr(reqAddr),
    .reqData(reqData), .flitOutData(flitOutData), .flitInData(flitInData),
    .rspCode(rspCode), .rspData(rspData)
  );
endmodule

// File: rtl/niPacketizerChk.sv
module niPacketizerChk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int FLIT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        reqCmd,
  input logic              reqAccept,
  input logic [2:0]        rspCode,
  input logic [DATA_W-1:0] rspData,
  input logic              rspValid,
  input logic              rspAccept,
  input logic [FLIT_W-1:0] flitOutData,
  input logic              flitOutTail,
  input logic              flitOutValid,
  input logic              flitOutReady,
  input logic              flitInTail,
  input logic              flitInValid,
  input logic              flitInReady
);
  AST_LOAD_STARTS_PACKET: assert property (@(posedge clk) disable iff (!rstN)
    (reqAccept && (reqCmd == 3'd1 || reqCmd == 3'd2)) |=> flitOutValid); // R2
  AST_BUSY_BLOCKS_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (flitOutValid && !(flitOutReady && flitOutTail)) |=> !reqAccept); // R3
  AST_FLIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (flitOutValid && !flitOutReady) |=> (flitOutValid && $stable(flitOutData) && $stable(flitOutTail))); // R8
  AST_RSP_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |-> $past(flitInValid && flitInTail && flitInReady)); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspAccept) |=> (rspValid && $stable(rspCode) && $stable(rspData))); // R10
  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspAccept) |=> !flitInReady); // R10
endmodule

bind niPacketizer niPacketizerChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLIT_W(FLIT_W)) uChk (
  .clk(clk), .rstN(rstN), .reqCmd(reqCmd), .reqAccept(reqAccept), .rspCode(rspCode),
  .rspData(rspData), .rspValid(rspValid), .rspAccept(rspAccept), .flitOutData(flitOutData),
  .flitOutTail(flitOutTail), .flitOutValid(flitOutValid), .flitOutReady(flitOutReady),
  .flitInTail(flitInTail), .flitInValid(flitInValid), .flitInReady(flitInReady)
);

// File: tb/sim_niPacketizer.sv
module sim_niPacketizer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  reqCmd = 3'd0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic        reqAccept;
  logic [2:0]  rspCode;
  logic [31:0] rspData;
  logic        rspValid;
  logic        rspAccept = 1'b0;
  logic [15:0] flitOutData;
  logic        flitOutTail;
  logic        flitOutValid;
  logic        flitOutReady = 1'b0;
  logic [15:0] flitInData = '0;
  logic        flitInTail = 1'b0;
  logic        flitInValid = 1'b0;
  logic        flitInReady;

  int total = 0;
  int bad = 0;
  int cycCnt = 0;
  bit rspAcceptEn = 1'b1;
  bit finished = 1'b0;
  logic [16:0] expFlit[$];
  logic [34:0] expRsp[$];

  always #5 clk = ~clk;

  niPacketizer u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] routeOf(input logic [31:0] a);
    case (a[31:30])
      2'd0: return 8'h03;
      2'd1: return 8'h05;
      2'd2: return 8'h09;
      default: return 8'h0C;
    endcase
  endfunction

  always @(posedge clk) begin
    cycCnt <= cycCnt + 1;
    #1;
    flitOutReady <= (cycCnt % 4) != 2;
    rspAccept    <= rspAcceptEn && ((cycCnt % 3) != 0);
  end

  // flit monitor: R4 R5 R6 R7
  always @(negedge clk) begin
    if (rstN && flitOutValid && flitOutReady) begin
      if (expFlit.size() == 0) chk(1'b0, "R7 unexpected flit", {47'd0, flitOutTail, flitOutData}, 64'd0);
      else begin
        logic [16:0] e;
        e = expFlit.pop_front();
        chk({flitOutTail, flitOutData} == e, "R5/R6/R7 flit", {47'd0, flitOutTail, flitOutData}, {47'd0, e});
      end
    end
  end

  // response monitor: R9 R10
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      chk(flitInReady == 1'b0, "R10 flitInReady while held", {63'd0, flitInReady}, 64'd0);
      if (rspAccept) begin
        if (expRsp.size() == 0) chk(1'b0, "R9 unexpected response", {29'd0, rspCode, rspData}, 64'd0);
        else begin
          logic [34:0] e;
          e = expRsp.pop_front();
          chk({rspCode, rspData} == e, "R9 response", {29'd0, rspCode, rspData}, {29'd0, e});
        end
      end
    end
  end

  task automatic sendReq(input logic [2:0] cmd, input logic [31:0] a, input logic [31:0] d);
    logic [7:0] rt;
    @(posedge clk); #2;
    reqCmd = cmd; reqAddr = a; reqData = d;
    @(negedge clk);
    while (!reqAccept) @(negedge clk);
    rt = routeOf(a);
    expFlit.push_back({1'b0, a[15:0]});
    expFlit.push_back({1'b0, a[31:16]});
    expFlit.push_back({(cmd == 3'd2), 5'd0, rt, cmd});
    if (cmd == 3'd1) begin
      expFlit.push_back({1'b0, d[15:0]});
      expFlit.push_back({1'b1, d[31:16]});
    end
    @(posedge clk); #2;
    reqCmd = 3'd0;
    @(negedge clk);
    chk(reqAccept == 1'b0, "R3 accept low while busy", {63'd0, reqAccept}, 64'd0);
  endtask

  task automatic sendRsp(input logic [2:0] code, input logic [31:0] d, input bit isRead);
    int n;
    logic [15:0] f [3];
    n = isRead ? 3 : 1;
    f[0] = {13'd0, code}; f[1] = d[15:0]; f[2] = d[31:16];
    expRsp.push_back({code, isRead ? d : 32'd0});
    @(posedge clk); #2;
    for (int i = 0; i < n; i++) begin
      flitInValid = 1'b1; flitInData = f[i]; flitInTail = (i == n - 1);
      @(negedge clk);
      while (!flitInReady) @(negedge clk);
      @(posedge clk); #2;
    end
    flitInValid = 1'b0; flitInTail = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((expFlit.size() != 0 || expRsp.size() != 0 || flitOutValid || rspValid) && guard < 500) begin
      @(negedge clk); guard++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    chk(reqAccept == 1'b1, "R1 reqAccept reset", {63'd0, reqAccept}, 64'd1);
    chk(flitOutValid == 1'b0, "R1 flitOutValid reset", {63'd0, flitOutValid}, 64'd0);
    chk(rspValid == 1'b0, "R1 rspValid reset", {63'd0, rspValid}, 64'd0);
    chk(flitInReady == 1'b1, "R1 flitInReady reset", {63'd0, flitInReady}, 64'd1);

    // R2: undefined command codes start nothing
    for (int c = 3; c < 8; c++) begin
      @(posedge clk); #2 reqCmd = 3'(c); reqAddr = 32'h4000_0000 + c;
      @(negedge clk);
      @(negedge clk);
      chk(flitOutValid == 1'b0, "R2 ignored cmd flitOutValid", {63'd0, flitOutValid}, 64'd0);
      chk(reqAccept == 1'b1, "R2 ignored cmd reqAccept", {63'd0, reqAccept}, 64'd1);
    end
    @(posedge clk); #2 reqCmd = 3'd0;

    // R4 R5 R6 R7 R8: all regions, reads and writes
    sendReq(3'd1, 32'h0000_1234, 32'hDEAD_BEEF);
    sendReq(3'd2, 32'h4567_89AB, 32'h0);
    sendReq(3'd1, 32'h8001_0002, 32'h0102_0304);
    sendReq(3'd2, 32'hC0FF_EE00, 32'h0);
    sendReq(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    drain();
    @(negedge clk);
    chk(reqAccept == 1'b1, "R3 accept after tail", {63'd0, reqAccept}, 64'd1);

    // R9: responses, read and write
    sendRsp(3'd1, 32'hCAFE_F00D, 1'b1);
    sendRsp(3'd3, 32'h1111_2222, 1'b0);
    sendRsp(3'd6, 32'h8000_0001, 1'b1);
    drain();

    // R11: requests and responses overlap
    fork
      begin
        sendReq(3'd2, 32'h1000_0010, 32'h0);
        sendReq(3'd1, 32'h9000_0020, 32'h5A5A_A5A5);
        sendReq(3'd2, 32'h5000_0030, 32'h0);
      end
      begin
        sendRsp(3'd2, 32'h0BAD_CAFE, 1'b1);
        sendRsp(3'd1, 32'h0, 1'b0);
      end
    join
    drain();

    // R10 R11: response held while core refuses it; request still accepted
    rspAcceptEn = 1'b0;
    sendRsp(3'd5, 32'h7654_3210, 1'b1);
    repeat (4) @(negedge clk);
    chk(rspValid == 1'b1, "R10 response held", {63'd0, rspValid}, 64'd1);
    chk({rspCode, rspData} == {3'd5, 32'h7654_3210}, "R10 held value", {29'd0, rspCode, rspData}, {29'd0, 3'd5, 32'h7654_3210});
    chk(flitInReady == 1'b0, "R10 input blocked", {63'd0, flitInReady}, 64'd0);
    chk(reqAccept == 1'b1, "R11 accept while response held", {63'd0, reqAccept}, 64'd1);
    sendReq(3'd1, 32'hA000_0040, 32'h1357_9BDF);
    rspAcceptEn = 1'b1;
    drain();

    chk(expFlit.size() == 0, "R6 all flits seen", 64'(expFlit.size()), 64'd0);
    chk(expRsp.size() == 0, "R9 all responses seen", 64'(expRsp.size()), 64'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule